// File: doc/BRIEF.md
# Polarize/Listen Cycle Sequencer

This block sets the timing of a magnetic precession sensor's measurement cycle. It counts a clock enable that marks each edge of a 32.768 kHz reference. A binary prescaler divides those enables down to a half-second step. The step drives a small cycle counter, and the counter's top bit chooses between two phases. While the top bit is clear the sensor coil is polarized. While it is set the coil is released and the block is in the listen phase, when the precession tone can be measured.

With 14 prescaler stages and a 4-bit counter, the full cycle polarizes for 4 s and then listens for 4 s. A select input picks a shortened cycle instead. In that mode the counter returns to zero in place of reaching a decoded count, which cuts the listen phase and still leaves well over the 3 s of polarization the sensor needs. The select is sampled only at reset and when a cycle starts, so a phase is never cut part way through.

The block gives a one-cycle marker in the first cycle of each listen phase, so that a frequency counter further down the chain can start gating at once. It also brings out a low prescaler stage as a calibration square wave, which is 2048 Hz with the default settings.

Top module: `pl_sequencer`

## Requirements
- R1: While `rst` is high at a clock edge, the prescaler and the cycle counter clear to zero and the select is captured. After that edge `cycle_count` is 0, `polarize` is 1, `listen` is 0, `pol_end` is 0 and `cal_tap` is 0.
- R2: `cycle_count` advances by one on the clock edge that completes every 2^PRE_BITS cycles with `ref_en` high. Cycles with `ref_en` low change neither the prescaler nor the counter.
- R3: In full mode (captured select = 0), `cycle_count` runs 0, 1, ... 2^CNT_BITS-1 and then returns to 0.
- R4: In short mode (captured select = 1), a step from count SHORT_WRAP-1 returns `cycle_count` to 0 in place of reaching SHORT_WRAP.
- R5: `polarize` is 1 exactly when the top bit of `cycle_count` is 0. `listen` is always its complement.
- R6: `pol_end` is high for exactly one clock cycle, namely the first cycle in which `polarize` is 0 after it was 1. It is never high at any other time.
- R7: `cal_tap` equals prescaler stage TAP_STAGE (bit TAP_STAGE-1 of the prescaler count). It changes level every 2^(TAP_STAGE-1) enabled cycles.
- R8: `short_sel` is captured only during reset and on the step where `cycle_count` returns to 0. The captured value sets the length of the whole cycle that follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| ref_en | input | 1 | One-cycle enable per reference clock period |
| short_sel | input | 1 | 1 selects the shortened cycle, 0 selects the full cycle |
| polarize | output | 1 | Coil polarize control level |
| listen | output | 1 | High during the listen phase |
| pol_end | output | 1 | One-cycle marker at the end of polarization |
| cal_tap | output | 1 | Calibration square wave from a low prescaler stage |
| cycle_count | output | CNT_BITS | Current cycle counter value |

## Verification
The bench builds the sequencer with PRE_BITS = 4, TAP_STAGE = 2, CNT_BITS = 4 and SHORT_WRAP = 10. One step then takes only 16 enabled cycles, and a full cycle takes 256. The counter and decode logic are the same as with the default settings. This lets many full and short cycles run, together with select changes at random points inside a cycle. The run also covers a select change held just before a wrap, long stretches with the enable low, and a reset in the middle of a cycle.

// File: rtl/pl_seq_pkg.sv
package pl_seq_pkg;

  typedef enum logic {
    PH_POLARIZE = 1'b0,
    PH_LISTEN   = 1'b1
  } phase_e;

  // The counter's top bit alone selects the phase.
  function automatic phase_e phase_of(input logic top_bit);
    return top_bit ? PH_LISTEN : PH_POLARIZE;
  endfunction

endpackage

// File: rtl/pl_prescaler.sv
module pl_prescaler #(
  parameter int STAGES = 14,
  parameter int TAP    = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic ref_en,
  output logic step,
  output logic tap
);
  localparam logic [STAGES-1:0] LAST = '1;

  logic [STAGES-1:0] div_q;

  always_ff @(posedge clk) begin
    if (rst)         div_q <= '0;
    else if (ref_en) div_q <= div_q + 1'b1;
  end

  assign step = ref_en && (div_q == LAST);
  assign tap  = div_q[TAP-1];

  // After a step, the prescaler must start again from zero.
  assert_step_restart_R2: assert property (@(posedge clk) disable iff (rst)
    step |=> (div_q == '0));

  // With no enable, the prescaler holds its value.
  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !ref_en |=> $stable(div_q));

endmodule

// File: rtl/pl_cycle_counter.sv
module pl_cycle_counter #(
  parameter int WIDTH = 4,
  parameter int WRAP  = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step,
  input  logic             short_sel,
  output logic [WIDTH-1:0] count,
  output logic [WIDTH-1:0] count_next,
  output logic             short_mode
);
  localparam logic [WIDTH-1:0] WRAP_LAST = WIDTH'(WRAP - 1);

  function automatic logic [WIDTH-1:0] advance(input logic [WIDTH-1:0] cur,
                                               input logic             shortened);
    if (shortened && cur == WRAP_LAST) return '0;
    return cur + 1'b1;
  endfunction

  logic [WIDTH-1:0] cnt_q;
  logic             mode_q;
  logic             wrap_evt;

  assign count_next = advance(cnt_q, mode_q);
  assign wrap_evt   = step && (count_next == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      mode_q <= short_sel;
    end else if (step) begin
      cnt_q <= count_next;
      if (wrap_evt) mode_q <= short_sel;
    end
  end

  assign count      = cnt_q;
  assign short_mode = mode_q;

  // Without a step, the count must not move.
  assert_no_step_hold_R3: assert property (@(posedge clk) disable iff (rst)
    !step |=> $stable(cnt_q));

  // In short mode the decoded count is never reached.
  assert_short_wrap_R4: assert property (@(posedge clk) disable iff (rst)
    (step && mode_q && cnt_q == WRAP_LAST) |=> (cnt_q == '0));

  // The captured mode changes only at a cycle boundary.
  assert_mode_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !wrap_evt |=> $stable(mode_q));

endmodule

// File: rtl/pl_sequencer.sv
module pl_sequencer #(
  parameter int PRE_BITS   = 14,
  parameter int TAP_STAGE  = 4,
  parameter int CNT_BITS   = 4,
  parameter int SHORT_WRAP = 10
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                ref_en,
  input  logic                short_sel,
  output logic                polarize,
  output logic                listen,
  output logic                pol_end,
  output logic                cal_tap,
  output logic [CNT_BITS-1:0] cycle_count
);
  import pl_seq_pkg::*;

  localparam int TOP = CNT_BITS - 1;

  logic                step;
  logic [CNT_BITS-1:0] cnt;
  logic [CNT_BITS-1:0] cnt_next;
  logic                mode_short;
  logic                fall_evt;
  logic                pol_end_q;
  phase_e              phase;

  pl_prescaler #(.STAGES(PRE_BITS), .TAP(TAP_STAGE)) u_pre (
    .clk    (clk),
    .rst    (rst),
    .ref_en (ref_en),
    .step   (step),
    .tap    (cal_tap)
  );

  pl_cycle_counter #(.WIDTH(CNT_BITS), .WRAP(SHORT_WRAP)) u_cnt (
    .clk        (clk),
    .rst        (rst),
    .step       (step),
    .short_sel  (short_sel),
    .count      (cnt),
    .count_next (cnt_next),
    .short_mode (mode_short)
  );

  // The edge that sets the counter's top bit ends polarization.
  assign fall_evt = step && !cnt[TOP] && cnt_next[TOP];

  always_ff @(posedge clk) begin
    if (rst) pol_end_q <= 1'b0;
    else     pol_end_q <= fall_evt;
  end

  assign phase       = phase_of(cnt[TOP]);
  assign polarize    = (phase == PH_POLARIZE);
  assign listen      = (phase == PH_LISTEN);
  assign pol_end     = pol_end_q;
  assign cycle_count = cnt;

  // The marker appears only on a polarize-to-listen transition.
  assert_marker_edge_R6: assert property (@(posedge clk) disable iff (rst)
    pol_end |-> ($past(polarize) && listen));

  // The marker is never longer than one cycle.
  assert_marker_single_R6: assert property (@(posedge clk) disable iff (rst)
    pol_end |=> !pol_end);

  // Every end of polarization produces the marker.
  assert_marker_present_R6: assert property (@(posedge clk) disable iff (rst)
    $fell(polarize) |-> pol_end);

  // In short mode, the listen phase ends by wrapping before the decoded count.
  assert_short_no_reach_R4: assert property (@(posedge clk) disable iff (rst)
    mode_short |-> (cycle_count < CNT_BITS'(SHORT_WRAP)));

endmodule

// File: tb/sim_pl_sequencer.sv
module sim_pl_sequencer;
  localparam int PB = 4;
  localparam int TS = 2;
  localparam int CB = 4;
  localparam int SW = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ref_en = 1'b0;
  logic short_sel = 1'b0;
  logic polarize, listen, pol_end, cal_tap;
  logic [CB-1:0] cycle_count;

  int vectors = 0;
  int errors  = 0;
  bit done    = 1'b0;

  // Reference model state.
  int m_pre  = 0;
  int m_cnt  = 0;
  bit m_mode = 1'b0;
  bit m_pend = 1'b0;

  always #4 clk = ~clk;

  pl_sequencer #(.PRE_BITS(PB), .TAP_STAGE(TS), .CNT_BITS(CB), .SHORT_WRAP(SW)) u0 (
    .clk(clk), .rst(rst), .ref_en(ref_en), .short_sel(short_sel),
    .polarize(polarize), .listen(listen), .pol_end(pol_end),
    .cal_tap(cal_tap), .cycle_count(cycle_count)
  );

  function automatic int next_count(int c, bit shortm);
    int n;
    n = (c + 1) % (1 << CB);
    if (shortm && (c + 1) == SW) n = 0;
    return n;
  endfunction

  function automatic bit exp_polarize(int c);
    return c < (1 << (CB - 1));
  endfunction

  function automatic bit exp_tap(int p);
    return ((p >> (TS - 1)) & 1) == 1;
  endfunction

  task automatic model_edge(bit r, bit en, bit sel);
    bit tk;
    int nc;
    if (r) begin
      m_pre = 0; m_cnt = 0; m_mode = sel; m_pend = 1'b0;
    end else begin
      tk = en && (m_pre == (1 << PB) - 1);
      if (en) m_pre = (m_pre + 1) % (1 << PB);
      m_pend = 1'b0;
      if (tk) begin
        nc = next_count(m_cnt, m_mode);
        m_pend = exp_polarize(m_cnt) && !exp_polarize(nc);
        if (nc == 0) m_mode = sel;
        m_cnt = nc;
      end
    end
  endtask

  task automatic compare(string tag);
    vectors++;
    if (cycle_count !== CB'(m_cnt)) begin
      errors++;
      $display("FAIL %s R2/R3/R4/R8 cycle_count actual=%0d expected=%0d", tag, cycle_count, m_cnt);
    end
    if (polarize !== exp_polarize(m_cnt) || listen !== !exp_polarize(m_cnt)) begin
      errors++;
      $display("FAIL %s R5 polarize/listen actual=%b/%b expected=%b/%b", tag,
               polarize, listen, exp_polarize(m_cnt), !exp_polarize(m_cnt));
    end
    if (pol_end !== m_pend) begin
      errors++;
      $display("FAIL %s R6 pol_end actual=%b expected=%b", tag, pol_end, m_pend);
    end
    if (cal_tap !== exp_tap(m_pre)) begin
      errors++;
      $display("FAIL %s R7 cal_tap actual=%b expected=%b", tag, cal_tap, exp_tap(m_pre));
    end
  endtask

  // Apply one cycle: inputs set at the falling edge, results sampled at the next one.
  task automatic cyc(bit r, bit en, bit sel, string tag);
    rst = r; ref_en = en; short_sel = sel;
    @(posedge clk);
    model_edge(r, en, sel);
    @(negedge clk);
    compare(tag);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    bit sel;
    void'($urandom(32'h1234abcd));
    @(negedge clk);

    // R1: reset state
    for (int i = 0; i < 3; i++) cyc(1'b1, 1'b1, 1'b0, "R1 reset");
    if (polarize !== 1'b1 || listen !== 1'b0 || pol_end !== 1'b0 || cycle_count !== '0 || cal_tap !== 1'b0) begin
      errors++;
      $display("FAIL R1 reset outputs actual=%b%b%b%b cnt=%0d expected=1000 cnt=0",
               polarize, listen, pol_end, cal_tap, cycle_count);
    end
    vectors++;

    // R3: full mode, enable always high, two full cycles
    for (int i = 0; i < 2 * 16 * 16 + 5; i++) cyc(1'b0, 1'b1, 1'b0, "R3 full");

    // R2: enable held low, nothing moves
    for (int i = 0; i < 60; i++) cyc(1'b0, 1'b0, 1'b1, "R2 idle");

    // R8: reset in full mode, request short mode late in the cycle
    cyc(1'b1, 1'b1, 1'b0, "R1 mid reset");
    while (m_cnt != SW - 1) cyc(1'b0, 1'b1, 1'b0, "R8 approach");
    for (int i = 0; i < 16; i++) cyc(1'b0, 1'b1, 1'b1, "R8 late select");
    vectors++;
    if (cycle_count !== CB'(SW)) begin
      errors++;
      $display("FAIL R8 running cycle was cut actual=%0d expected=%0d", cycle_count, SW);
    end

    // R4: the next cycle runs short
    for (int i = 0; i < 3 * 16 * 16; i++) cyc(1'b0, 1'b1, 1'b1, "R4 short");

    // Random mix of enables and select changes
    sel = 1'b0;
    for (int i = 0; i < 40000; i++) begin
      if ($urandom_range(0, 399) == 0) sel = !sel;
      if ($urandom_range(0, 9999) == 0) cyc(1'b1, 1'b1, sel, "R1 random reset");
      else cyc(1'b0, $urandom_range(0, 3) != 0, sel, "random");
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule